// File: doc/BRIEF.md
# Parallel-Output Multi-Lane ADC Read Sequencer

This block runs one acquisition of an eight-channel, 16-bit serial ADC that shifts its results out over four data lanes at once. On a start request it raises a convert-start pulse and waits out the conversion time. It then opens a fixed burst of serial-clock cycles and captures two bits per lane per system cycle, one from each clock edge. When the last bit is in, it presents all eight samples together with a one-cycle valid strobe. Every phase is a fixed number of 8 ns system cycles, so an acquisition always takes the same time.

The serial clock leaves the chip through an output DDR register, and the data comes back through an input DDR register after a board round trip. The capture window is therefore the serial-clock window delayed by a fixed latency of round-trip cycles plus DDR-register cycles (6 + 2 = 8 by default). The I/O registers are not part of the block. The `sck_en_o` output gates the outgoing clock. The inputs `sdo_rise_i` and `sdo_fall_i` are the two bits per lane that the input DDR register delivers in one system cycle.

Cycle numbers below count from the rising edge that samples the start request: that edge ends cycle 0.

Top module: `adc_burst_reader`

## Requirements
- R1: While reset is held and after its release with no request, `busy_o`, `valid_o`, `cnv_o` and `sck_en_o` are 0 and `samples_o` is all zeros.
- R2: A start request sampled while idle drives `cnv_o` high in cycles 1 to 4 and low otherwise.
- R3: Between the convert pulse and the serial burst there are exactly 57 cycles (cycles 5 to 61) with both `cnv_o` and `sck_en_o` low.
- R4: `sck_en_o` is high for exactly 16 consecutive cycles, cycles 62 to 77, and never together with `cnv_o`.
- R5: Lane bits are captured only in cycles 70 to 85, which is the burst delayed by 8 cycles. In each of these cycles `sdo_rise_i` carries the earlier bit and `sdo_fall_i` the later bit. Input values in any other cycle have no effect on the samples.
- R6: Each lane carries a 32-bit word, most significant bit first. For lane l, the first 16 bits form channel 2l and the last 16 bits form channel 2l+1. Channel c appears on `samples_o[16*c +: 16]` as an unaltered two's-complement value, so 0x8000 reads as -32768.
- R7: `valid_o` is high for exactly one cycle, cycle 87, and all eight channels change together at that cycle. At every other cycle `samples_o` holds its previous value.
- R8: `busy_o` is high in cycles 1 to 86 and low when `valid_o` rises. A start request is accepted again from cycle 87 on.
- R9: A start request that arrives while `busy_o` is high is ignored, and the running acquisition keeps its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 8 ns period |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request for one acquisition |
| cnv_o | output | 1 | Convert-start pulse to the ADC |
| sck_en_o | output | 1 | Serial-clock gate to the output DDR register |
| sdo_rise_i | input | 4 | Per-lane bit from the rising serial-clock edge |
| sdo_fall_i | input | 4 | Per-lane bit from the falling serial-clock edge |
| busy_o | output | 1 | Acquisition in progress |
| valid_o | output | 1 | One-cycle strobe marking new samples |
| samples_o | output | 128 | Eight 16-bit two's-complement samples, channel 0 in the low bits |

## Verification
A phase counter that loads the wrong value moves `cnv_o` or `sck_en_o` by whole cycles, and that shows in the very acquisition where it happens. A delay line of the wrong depth shifts the capture window. The samples then take in one or more random bits from outside the window, or lose their final bits, and this appears at the next valid strobe, at most 87 cycles later. A swapped edge order or a wrong lane-to-channel slice shows as a wrong value on specific channels at that same strobe. A start that leaks through while busy shortens the acquisition, and that shows on the convert pulse within a cycle.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CNVH,
    S_CONV,
    S_READ,
    S_WAIT,
    S_DONE
  } rd_state_t;

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int T_CNVH = 4,
  parameter int T_CONV = 57,
  parameter int T_READ = 16,
  parameter int T_LAT  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic cnv_o,
  output logic sck_en_o,
  output logic busy_o,
  output logic done_o
);

  localparam int MAXT = max_of3(T_CNVH, T_CONV, max_of3(T_READ, T_LAT, 1));
  localparam int CW   = $clog2(MAXT + 1);

  rd_state_t      st;
  logic [CW-1:0]  cnt;
  logic           cnt_zero;
  logic           start_accept;
  logic           start_ignored;

  assign cnt_zero      = (cnt == '0);
  assign start_accept  = start_i && (st == S_IDLE);
  assign start_ignored = start_i && (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start_accept) begin
          st  <= S_CNVH;
          cnt <= CW'(T_CNVH - 1);
        end
        S_CNVH: if (cnt_zero) begin
          st  <= S_CONV;
          cnt <= CW'(T_CONV - 1);
        end else cnt <= cnt - 1'b1;
        S_CONV: if (cnt_zero) begin
          st  <= S_READ;
          cnt <= CW'(T_READ - 1);
        end else cnt <= cnt - 1'b1;
        S_READ: if (cnt_zero) begin
          st  <= S_WAIT;
          cnt <= CW'(T_LAT - 1);
        end else cnt <= cnt - 1'b1;
        S_WAIT: if (cnt_zero) begin
          st  <= S_DONE;
          cnt <= '0;
        end else cnt <= cnt - 1'b1;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cnv_o    = (st == S_CNVH);
  assign sck_en_o = (st == S_READ);
  assign busy_o   = (st != S_IDLE);
  assign done_o   = (st == S_DONE);

  // Run-length observers for the assertions below.
  logic [CW:0] cnv_run;
  logic [CW:0] gap_run;
  logic [CW:0] sck_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_run <= '0;
      gap_run <= '0;
      sck_run <= '0;
    end else begin
      cnv_run <= cnv_o ? cnv_run + 1'b1 : '0;
      gap_run <= cnv_o ? '0 : ((st == S_CONV) ? gap_run + 1'b1 : gap_run);
      sck_run <= sck_en_o ? sck_run + 1'b1 : '0;
    end
  end

  a_r2_cnv_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_o) |-> (cnv_run == (CW+1)'(T_CNVH)));

  a_r3_conv_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_en_o) |-> (gap_run == (CW+1)'(T_CONV)));

  a_r4_sck_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck_en_o) |-> (sck_run == (CW+1)'(T_READ)));

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnv_o && sck_en_o));

  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ignored && !cnv_o) |=> !cnv_o);

  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> (busy_o && cnv_o));

endmodule

// File: rtl/adc_rd_dly.sv
module adc_rd_dly #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [DEPTH-1:0] stage;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= 1'b0;
          else        stage[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[i] <= 1'b0;
          else        stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign dout = stage[DEPTH-1];

endmodule

// File: rtl/adc_rd_lane.sv
module adc_rd_lane #(
  parameter int BITS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic            bit_rise,
  input  logic            bit_fall,
  output logic [BITS-1:0] word_o
);

  logic [BITS-1:0] sr;

  // Two bits per cycle: the rising-edge bit is the earlier, more significant one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr <= '0;
    else if (cap_en) sr <= {sr[BITS-3:0], bit_rise, bit_fall};
  end

  assign word_o = sr;

endmodule

// File: rtl/adc_burst_reader.sv
module adc_burst_reader #(
  parameter int N_LANES     = 4,
  parameter int CH_PER_LANE = 2,
  parameter int SAMPLE_W    = 16,
  parameter int T_CNVH      = 4,
  parameter int T_CONV      = 57,
  parameter int T_RTT       = 6,
  parameter int T_DDR       = 2,
  parameter bit OFFSET_BIN  = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  output logic                         cnv_o,
  output logic                         sck_en_o,
  input  logic [N_LANES-1:0]           sdo_rise_i,
  input  logic [N_LANES-1:0]           sdo_fall_i,
  output logic                         busy_o,
  output logic                         valid_o,
  output logic [N_LANES*CH_PER_LANE*SAMPLE_W-1:0] samples_o
);

  localparam int N_CH      = N_LANES * CH_PER_LANE;
  localparam int LANE_BITS = CH_PER_LANE * SAMPLE_W;
  localparam int T_READ    = LANE_BITS / 2;
  localparam int T_LAT     = T_RTT + T_DDR;
  localparam int CCW       = $clog2(T_READ + 1);

  // Raw ADC code to two's complement; offset-binary parts flip the sign bit.
  function automatic logic [SAMPLE_W-1:0] fmt_sample(input logic [SAMPLE_W-1:0] raw);
    if (OFFSET_BIN) return {~raw[SAMPLE_W-1], raw[SAMPLE_W-2:0]};
    else            return raw;
  endfunction

  logic done;
  logic cap_en;
  logic [LANE_BITS-1:0]       lane_word [N_LANES];
  logic [N_CH*SAMPLE_W-1:0]   samp_next;
  logic [N_CH*SAMPLE_W-1:0]   samp_q;
  logic                       valid_q;

  adc_rd_seq #(
    .T_CNVH (T_CNVH),
    .T_CONV (T_CONV),
    .T_READ (T_READ),
    .T_LAT  (T_LAT)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cnv_o    (cnv_o),
    .sck_en_o (sck_en_o),
    .busy_o   (busy_o),
    .done_o   (done)
  );

  adc_rd_dly #(.DEPTH(T_LAT)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (sck_en_o),
    .dout  (cap_en)
  );

  generate
    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      adc_rd_lane #(.BITS(LANE_BITS)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .bit_rise (sdo_rise_i[l]),
        .bit_fall (sdo_fall_i[l]),
        .word_o   (lane_word[l])
      );
      for (genvar k = 0; k < CH_PER_LANE; k++) begin : g_ch
        assign samp_next[(l*CH_PER_LANE+k)*SAMPLE_W +: SAMPLE_W] =
          fmt_sample(lane_word[l][LANE_BITS-1-k*SAMPLE_W -: SAMPLE_W]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= done;
      if (done) samp_q <= samp_next;
    end
  end

  assign samples_o = samp_q;
  assign valid_o   = valid_q;

  // Capture-count observer for the window assertion.
  logic [CCW-1:0] cap_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_cnt <= '0;
    else if (done)   cap_cnt <= '0;
    else if (cap_en) cap_cnt <= cap_cnt + 1'b1;
  end

  a_r5_cap_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cap_cnt == CCW'(T_READ)));

  a_r5_cap_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (busy_o && !sck_en_o || busy_o));

  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(samples_o));

  a_r8_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !busy_o);

endmodule

// File: tb/tb_adc_burst_reader.sv
module tb_adc_burst_reader;

  localparam int CLK_PERIOD = 8;
  localparam int NL = 4;
  localparam int NC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [NL-1:0] sdo_rise_i = '0;
  logic [NL-1:0] sdo_fall_i = '0;
  logic cnv_o, sck_en_o, busy_o, valid_o;
  logic [NC*16-1:0] samples_o;

  int checks = 0;
  int fails = 0;
  logic [31:0] cur_words [NL];
  logic [NC*16-1:0] prev_samples = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_burst_reader dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .cnv_o(cnv_o), .sck_en_o(sck_en_o),
    .sdo_rise_i(sdo_rise_i), .sdo_fall_i(sdo_fall_i),
    .busy_o(busy_o), .valid_o(valid_o), .samples_o(samples_o)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Channel c: lane c/2; even channel is the upper half of the lane word.
  function automatic logic [15:0] exp_chan(input int c);
    logic [31:0] w;
    w = cur_words[c / 2];
    if (c % 2 == 0) return w[31:16];
    return w[15:0];
  endfunction

  function automatic logic [127:0] exp_all();
    logic [127:0] v;
    v = '0;
    for (int c = 0; c < NC; c++) v[c*16 +: 16] = exp_chan(c);
    return v;
  endfunction

  task automatic run_conv(input bit spam);
    logic [127:0] expv;
    @(negedge clk);
    start_i = 1'b1;
    for (int k = 1; k <= 90; k++) begin
      @(negedge clk);
      start_i = (spam && k <= 86) ? 1'($urandom % 2) : 1'b0;
      if (k >= 70 && k <= 85) begin
        for (int l = 0; l < NL; l++) begin
          sdo_rise_i[l] = cur_words[l][31 - 2*(k-70)];
          sdo_fall_i[l] = cur_words[l][30 - 2*(k-70)];
        end
      end else begin
        sdo_rise_i = 4'($urandom);
        sdo_fall_i = 4'($urandom);
      end
      check(cnv_o == (k <= 4), "R2 cnv_o", 128'(cnv_o), 128'(k <= 4));
      if (k >= 5 && k <= 61)
        check(!cnv_o && !sck_en_o, "R3 conversion gap", 128'({cnv_o, sck_en_o}), 128'(0));
      check(sck_en_o == (k >= 62 && k <= 77), "R4 sck_en_o", 128'(sck_en_o), 128'(k >= 62 && k <= 77));
      check(busy_o == (k <= 86), "R8/R9 busy_o", 128'(busy_o), 128'(k <= 86));
      check(valid_o == (k == 87), "R7 valid_o", 128'(valid_o), 128'(k == 87));
      if (k == 86)
        check(samples_o == prev_samples, "R7 hold before valid", samples_o, prev_samples);
      if (k == 87 || k == 89) begin
        expv = exp_all();
        for (int c = 0; c < NC; c++)
          check(samples_o[c*16 +: 16] == expv[c*16 +: 16], "R5/R6 channel", 128'(samples_o[c*16 +: 16]), 128'(expv[c*16 +: 16]));
      end
    end
    prev_samples = exp_all();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!busy_o && !valid_o && !cnv_o && !sck_en_o && samples_o == '0, "R1 in reset", samples_o, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy_o && !valid_o && !cnv_o && !sck_en_o && samples_o == '0, "R1 after reset", samples_o, '0);

    // Directed: sign extremes and all-ones/zero patterns.
    cur_words[0] = 32'h8000_7FFF;
    cur_words[1] = 32'hFFFF_0000;
    cur_words[2] = 32'h0001_FFFE;
    cur_words[3] = 32'hA5A5_5A5A;
    run_conv(1'b0);
    check($signed(samples_o[15:0]) == -32768, "R6 two's complement ch0", 128'(samples_o[15:0]), 128'(16'h8000));
    check($signed(samples_o[31:16]) == 32767, "R6 two's complement ch1", 128'(samples_o[31:16]), 128'(16'h7FFF));

    // Random words, some runs with start requests hammered during busy (R9).
    for (int n = 0; n < 8; n++) begin
      for (int l = 0; l < NL; l++) cur_words[l] = $urandom;
      run_conv(n % 2 == 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule